// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external 128K x 8 asynchronous static RAM. The host offers one request at a time on a valid/ready handshake with a 17-bit word address, a write flag and a write byte. The controller turns each accepted request into a complete read or write cycle on the memory pins. Every phase length is a whole number of clocks, derived by rounding up from nanosecond parameters and the clock period. Read data comes back on a separate port, marked by a single-cycle valid pulse.

The memory is selected only when the active-low enable is low and the active-high enable is high. Between cycles the controller leaves the part deselected, so it draws standby current and its data pins float. A write first lowers the write strobe while the part is still deselected. It waits a turnaround interval so that any read data left on the bus can float away. Only then does it select the part and drive the write byte, which keeps the memory's own outputs in high-Z for the whole write. A sleep input parks the part in deselected standby. Releasing sleep starts a recovery lockout that must end before the next request is accepted.

FSM states: IDLE (waiting for a request), READ (enables and output enable active), WR_TURN (strobe low, part deselected, bus released), WR_PULSE (part selected, byte driven), SLEEP (standby held) and RECOVER (lockout after sleep). Transitions: IDLE to SLEEP on sleep; IDLE to READ or WR_TURN on an accepted request; READ to IDLE and WR_PULSE to IDLE when their timer expires; WR_TURN to WR_PULSE when its timer expires; SLEEP to RECOVER when sleep falls; RECOVER to IDLE when the lockout expires; RECOVER to SLEEP if sleep returns.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and right after reset, req_ready is 1, rd_valid is 0, mem_ce1_n is 1, mem_ce2 is 0, mem_we_n is 1, mem_oe_n is 1 and mem_dq_oe is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until the cycle it started has finished.
- R3: A read holds mem_ce1_n=0, mem_ce2=1, mem_oe_n=0 and mem_we_n=1 for N_RD = max(ceil(T_CYCLE_NS/CLK_PERIOD_NS), ceil(T_OE_NS/CLK_PERIOD_NS)) clocks. It samples mem_dq_in on the last of those clocks and shows the byte on rd_data with rd_valid high for exactly one clock. That clock is the (N_RD+1)-th clock after the accepting edge.
- R4: A write lowers mem_we_n while the part is deselected and keeps it deselected for N_TURN = ceil(T_TURN_NS/CLK_PERIOD_NS) clocks. Only then does it select the part. mem_oe_n stays 1 for the whole write.
- R5: The selected, strobe-low part of a write lasts N_PULSE clocks, with mem_dq_oe=1 and mem_dq_out equal to the write byte throughout. N_PULSE is the largest of ceil(T_WP_NS), ceil(T_CW_NS) and ceil(T_DS_NS) in clocks, and of N_CYC-N_TURN. mem_we_n and the enables are released on the same edge.
- R6: mem_dq_oe is 1 only while the part is selected, mem_we_n is 0 and mem_oe_n is 1.
- R7: While sleep_i is 1 in the idle state, req_ready is 0 at once and the part stays deselected. Requests offered during sleep cause no memory access. Sleep raised during a cycle lets that cycle complete.
- R8: After sleep_i falls, req_ready stays 0 for N_REC = ceil(RECOVERY_NS/CLK_PERIOD_NS) clocks. If sleep returns during the lockout, the lockout restarts in full at the next release.
- R9: A read returns the byte most recently written to the same address, including addresses 0x00000 and 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Standby request; holds the memory deselected |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-clock pulse: rd_data holds read byte |
| rd_data | output | 8 | Read byte |
| mem_addr | output | 17 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Read/write strobe, low = write |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data seen on the memory data pins |

## Verification
Several properties are checked on every clock. The data drive appears only inside a selected write with the output enable high. Selection never rises with the strobe low unless the strobe was already low on the clock before. Ready implies a deselected part, and each accept drops ready. The read pulse is one clock wide, and ready stays low on the clock after sleep is released. Phase lengths, round-trip data integrity, the full length of the lockout, its restart, and the completion of a cycle interrupted by sleep are visible only in the bench's scenarios. There, a timing-aware memory model returns unknown data on early samples.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WR_TURN,
        ST_WR_PULSE,
        ST_SLEEP,
        ST_RECOVER
    } ctrl_state_e;

    // Whole clocks needed to cover a delay, rounded up, never below one.
    function automatic int unsigned ns_to_clocks(input int unsigned ns,
                                                 input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] len_i,
    output logic             last_o
);
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - WIDTH'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - WIDTH'(1);
        end
    end

    assign last_o = (cnt_q == '0);

    // R10-style sizing guard: a phase of zero clocks would underflow
    p_len_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (len_i != '0));

    p_count_steps_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !last_o) |=> (cnt_q == $past(cnt_q) - WIDTH'(1)));

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [DW-1:0] dq_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= capture_i;
            if (capture_i) begin
                data_o <= dq_i;
            end
        end
    end

    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture_i) |-> $stable(data_o));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW            = 17,
    parameter int unsigned DW            = 8,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned T_CYCLE_NS    = 85,
    parameter int unsigned T_OE_NS       = 45,
    parameter int unsigned T_WP_NS       = 60,
    parameter int unsigned T_CW_NS       = 75,
    parameter int unsigned T_DS_NS       = 35,
    parameter int unsigned T_TURN_NS     = 30,
    parameter int unsigned RECOVERY_NS   = 5000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_i,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int unsigned N_CYC   = ns_to_clocks(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RD    = max_u(N_CYC, ns_to_clocks(T_OE_NS, CLK_PERIOD_NS));
    localparam int unsigned N_TURN  = ns_to_clocks(T_TURN_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WMIN  = max_u(ns_to_clocks(T_WP_NS, CLK_PERIOD_NS),
                                      max_u(ns_to_clocks(T_CW_NS, CLK_PERIOD_NS),
                                            ns_to_clocks(T_DS_NS, CLK_PERIOD_NS)));
    localparam int unsigned N_REST  = (N_CYC > N_TURN) ? (N_CYC - N_TURN) : 1;
    localparam int unsigned N_PULSE = max_u(N_WMIN, N_REST);
    localparam int unsigned N_REC   = ns_to_clocks(RECOVERY_NS, CLK_PERIOD_NS);
    localparam int unsigned N_PHMAX = max_u(N_RD, max_u(N_TURN, N_PULSE));
    localparam int unsigned PH_W    = $clog2(N_PHMAX + 1);
    localparam int unsigned REC_W   = $clog2(N_REC + 1);

    ctrl_state_e      state_q, state_d;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic             accept;
    logic             phase_load;
    logic [PH_W-1:0]  phase_len;
    logic             phase_last;
    logic             rec_load;
    logic             rec_last;
    logic             rd_capture;

    assign req_ready = (state_q == ST_IDLE) && !sleep_i;
    assign accept    = req_valid && req_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sleep_i)     state_d = ST_SLEEP;
                else if (accept) state_d = req_write ? ST_WR_TURN : ST_READ;
            end
            ST_READ:     if (phase_last) state_d = ST_IDLE;
            ST_WR_TURN:  if (phase_last) state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (phase_last) state_d = ST_IDLE;
            ST_SLEEP:    if (!sleep_i)   state_d = ST_RECOVER;
            ST_RECOVER: begin
                if (sleep_i)       state_d = ST_SLEEP;
                else if (rec_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // phase length chosen by the state being entered
    always_comb begin
        unique case (state_d)
            ST_READ:     phase_len = PH_W'(N_RD);
            ST_WR_TURN:  phase_len = PH_W'(N_TURN);
            ST_WR_PULSE: phase_len = PH_W'(N_PULSE);
            default:     phase_len = PH_W'(1);
        endcase
    end

    assign phase_load = (state_d != state_q);
    assign rec_load   = (state_d == ST_RECOVER) && (state_q != ST_RECOVER);
    assign rd_capture = (state_q == ST_READ) && phase_last;

    sram_cycle_timer #(.WIDTH(PH_W)) phase_timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (phase_load),
        .len_i  (phase_len),
        .last_o (phase_last)
    );

    sram_cycle_timer #(.WIDTH(REC_W)) lockout_timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rec_load),
        .len_i  (REC_W'(N_REC)),
        .last_o (rec_last)
    );

    sram_read_capture #(.DW(DW)) capture_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (rd_capture),
        .dq_i      (mem_dq_in),
        .data_o    (rd_data),
        .valid_o   (rd_valid)
    );

    // pin decode
    always_comb begin
        mem_ce1_n  = 1'b1;
        mem_ce2    = 1'b0;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        mem_addr   = addr_q;
        mem_dq_out = wdata_q;
        unique case (state_q)
            ST_READ: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_oe_n  = 1'b0;
            end
            ST_WR_TURN: begin
                mem_we_n  = 1'b0;
            end
            ST_WR_PULSE: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    p_drive_only_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_we_n && !mem_ce1_n && mem_ce2));

    p_select_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce1_n) && !mem_we_n) |-> $past(!mem_we_n));

    p_ready_means_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n));

    p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_release_locks_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !sleep_i) |=> !req_ready);

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

    localparam int unsigned PER   = 20;
    localparam int unsigned REC   = 1000;

    function automatic int unsigned clk_of(input int unsigned ns);
        return (ns + PER - 1) / PER;
    endfunction

    localparam int unsigned B_RD    = (clk_of(85) > clk_of(45)) ? clk_of(85) : clk_of(45);
    localparam int unsigned B_TURN  = clk_of(30);
    localparam int unsigned B_PULSE = 4; // max(3 wp, 4 cw, 2 ds, 5-2)
    localparam int unsigned B_REC   = clk_of(REC);
    localparam int unsigned B_ACC   = clk_of(85);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sleep_i = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PER/2) clk = ~clk;

    sram_async_ctrl #(.CLK_PERIOD_NS(PER), .RECOVERY_NS(REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // ---------------- memory model with access timing ----------------
    logic [7:0] model_mem [int unsigned];
    logic [7:0] exp_mem   [int unsigned];
    logic [7:0] rd_byte = 8'h00;
    int         age = -1;
    logic [16:0] last_addr = '0;
    wire sel = !mem_ce1_n && mem_ce2;

    assign mem_dq_in = (age >= int'(B_ACC) - 1) ? rd_byte : 8'hxx;

    always @(posedge clk) begin
        #1;
        if (sel && mem_we_n && !mem_oe_n) begin
            if (age < 0 || mem_addr != last_addr) age = 0;
            else age = age + 1;
            rd_byte = model_mem.exists(32'(mem_addr)) ? model_mem[32'(mem_addr)] : 8'h00;
        end else begin
            age = -1;
        end
        last_addr = mem_addr;
    end

    // ---------------- write phase monitor (R4, R5, R6) ----------------
    int  turn_n = 0, pulse_n = 0;
    bit  drive_ok = 1'b1, oe_ok = 1'b1, prev_we_n = 1'b1;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sel && !mem_we_n && mem_dq_oe) model_mem[32'(mem_addr)] = mem_dq_out;
            if (mem_dq_oe && !(sel && !mem_we_n && mem_oe_n))
                check(1'b0, "R6 drive outside write pulse", 1, 0);
            if (!mem_we_n) begin
                if (!sel) begin
                    if (pulse_n != 0) check(1'b0, "R4 deselect before strobe release", pulse_n, 0);
                    turn_n++;
                end else begin
                    pulse_n++;
                    if (!mem_dq_oe) drive_ok = 1'b0;
                end
                if (!mem_oe_n) oe_ok = 1'b0;
            end else if (!prev_we_n) begin
                check(turn_n == int'(B_TURN), "R4 turnaround clocks", turn_n, B_TURN);
                check(pulse_n == int'(B_PULSE), "R5 write pulse clocks", pulse_n, B_PULSE);
                check(drive_ok, "R5 data driven through pulse", drive_ok, 1);
                check(oe_ok, "R4 output enable high in write", oe_ok, 1);
                check(!sel, "R5 enables released with strobe", sel, 0);
                turn_n = 0; pulse_n = 0; drive_ok = 1'b1; oe_ok = 1'b1;
            end
            prev_we_n = mem_we_n;
        end
    end

    // ---------------- host tasks ----------------
    task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        issue(1'b1, a, d);
        exp_mem[32'(a)] = d;
        @(negedge clk);
        check(!req_ready, "R2 ready low after accept", req_ready, 0);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_read(input logic [16:0] a, input bit sleep_mid);
        int n;
        logic [7:0] e;
        e = exp_mem.exists(32'(a)) ? exp_mem[32'(a)] : 8'h00;
        issue(1'b0, a, 8'h00);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                check(!req_ready, "R2 ready low during read", req_ready, 0);
                check(sel && !mem_oe_n && mem_we_n, "R3 read pin levels", {sel, mem_oe_n, mem_we_n}, 3'b101);
                if (sleep_mid) sleep_i = 1'b1;
            end
        end while (!rd_valid && n < 50);
        check(n == int'(B_RD) + 1, "R3 read latency", n, B_RD + 1);
        check(rd_data === e, "R9 read data", rd_data, e);
        @(negedge clk);
        check(!rd_valid, "R3 valid is one clock", rd_valid, 0);
    endtask

    task automatic measure_lockout(input string tag);
        int n;
        @(negedge clk);
        sleep_i = 1'b0;
        n = 0;
        forever begin
            @(negedge clk);
            if (req_ready || n > 500) break;
            n++;
        end
        check(n == int'(B_REC), tag, n, B_REC);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready && !rd_valid && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe,
              "R1 reset pin state", {req_ready, rd_valid, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe},
              7'b1010110);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && mem_ce1_n && !mem_ce2, "R1 idle after reset", {req_ready, mem_ce1_n, mem_ce2}, 3'b110);

        // R9 address extremes
        do_write(17'h00000, 8'hA5);
        do_write(17'h1FFFF, 8'h5A);
        do_read(17'h00000, 1'b0);
        do_read(17'h1FFFF, 1'b0);
        do_read(17'h00123, 1'b0);

        // mixed random traffic over a small window plus extremes
        for (int i = 0; i < 120; i++) begin
            logic [16:0] a;
            logic [7:0]  d;
            int unsigned r;
            r = $urandom;
            a = (r[3:0] == 4'd0) ? 17'h1FFFF : (r[3:0] == 4'd1) ? 17'h0 : 17'(r[31:26]);
            d = 8'($urandom);
            if ($urandom % 2 == 0) do_write(a, d);
            else do_read(a, 1'b0);
        end

        // R7 sleep in idle: immediate ready drop and no access on offered requests
        @(negedge clk);
        sleep_i = 1'b1;
        #1 check(!req_ready, "R7 ready drops with sleep", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00000; req_wdata = 8'hEE;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (sel || !mem_we_n) check(1'b0, "R7 access during sleep", {sel, mem_we_n}, 2'b01);
        end
        check(mem_ce1_n && !mem_ce2, "R7 deselected in sleep", {mem_ce1_n, mem_ce2}, 2'b10);
        req_valid = 1'b0;
        measure_lockout("R8 lockout length");
        do_read(17'h00000, 1'b0); // still A5 unless random traffic changed it: exp_mem tracks

        // R7 sleep raised mid-read: read completes, then standby
        do_read(17'h1FFFF, 1'b1);
        check(!req_ready && mem_ce1_n && !mem_ce2, "R7 standby after finished cycle",
              {req_ready, mem_ce1_n, mem_ce2}, 3'b010);

        // R8 lockout restart when sleep returns
        @(negedge clk);
        sleep_i = 1'b0;
        repeat (10) @(negedge clk);
        check(!req_ready, "R8 ready low in lockout", req_ready, 0);
        sleep_i = 1'b1;
        repeat (3) @(negedge clk);
        check(!req_ready && mem_ce1_n, "R8 back in sleep", {req_ready, mem_ce1_n}, 2'b01);
        measure_lockout("R8 lockout restarts in full");

        do_write(17'h0ABCD, 8'h3C);
        do_read(17'h0ABCD, 1'b0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule